// File: doc/BRIEF.md
# Serial Command Interface for a Receiver Configuration Block

This block is the host-facing control port of a radio receiver. A microcontroller talks to it over a four-wire synchronous serial link: a serial clock, a serial data input, an active-low select, and a serial data output that the pad stays off from unless the block is selected. The host shifts in 16-bit command words, most significant bit first. Each word either writes one of the receiver's configuration registers or asks for a status readout.

All serial pins are brought into the block's system clock domain through a short synchroniser chain. Serial clock edges are detected there. Because of this, the serial clock must run several times slower than the system clock. The configuration registers hold the channel frequency word, the baseband bandwidth setting, the FIFO control byte, the AFC control byte and a sensitive-reset enable. They are exposed as plain outputs for the analog and datapath logic around the block. Status flags arrive on input ports from that logic and are returned to the host on demand.

A software reset command returns every register to its default value. This happens only when the sensitive-reset enable has been set. Every reset, whether from power-on or from software, shows up as a one-cycle pulse.

Top module: `serial_cmd_if`

## Requirements
- R1: SDI is captured only on rising SCK edges seen while `sel_n` is low, and the first captured bit is the most significant bit of the command. SCK and SDI activity while `sel_n` is high changes nothing.
- R2: A command that starts with 1 is a write. It is decoded once, when the 16th rising edge arrives. A frame that ends (select goes high) before the 16th edge has no effect. Rising edges after the 16th in the same frame are ignored.
- R3: Taking `sel_n` high clears the bit counter and the read state, so the next frame is decoded from its first bit.
- R4: A command that starts with 0 is a status read and never writes a register. The status word is captured at the first rising edge. Its bit 15 appears on `sdo` after the next falling SCK edge. Each further falling edge moves one bit on, MSB first. Once all 16 bits are out, `sdo` is 0.
- R5: The status word is laid out as follows: bit 15 is clock-recovery lock, bit 14 is the AFC-cycle toggle, bit 13 is AFC-same-result, bit 12 is the offset sign, bits 11:7 are the offset magnitude, and bits 6:0 are 0.
- R6: `sdo_oe` is low and `sdo` is 0 whenever `sel_n` is high. `sdo_oe` is high throughout a selected frame.
- R7: Command `Axxx` (hex) carries a 12-bit frequency word F in bits 11:0. The block stores F only when 96 ≤ F ≤ 3903. Otherwise the previous value stays.
- R8: Command `C0vv` writes vv to the bandwidth register, `C4vv` to the AFC register and `CAvv` to the FIFO register. `DAvv` writes bit 0 of vv to the sensitive-reset enable. Any other write opcode changes nothing.
- R9: Command `FF00` restores every register to its default when the sensitive-reset enable is 1. When the enable is 0, the command is ignored.
- R10: `cfg_reset_pulse` is high for exactly one cycle after power-on reset is released, and for exactly one cycle after an accepted software reset. While it is high, all registers hold their defaults: frequency 0x640, bandwidth 0x40, AFC 0x13, FIFO 0x80, enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sel_n | input | 1 | Active-low select |
| stat_lock | input | 1 | Clock-recovery lock flag |
| stat_afc_toggle | input | 1 | Toggles each AFC cycle |
| stat_afc_same | input | 1 | AFC measured same result twice |
| stat_offs_sign | input | 1 | Sign of measured frequency offset |
| stat_offs_mag | input | 5 | Magnitude of measured frequency offset |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Pad enable for sdo (low = high impedance) |
| cfg_freq | output | 12 | Channel frequency word |
| cfg_bw | output | 8 | Bandwidth setting |
| cfg_afc | output | 8 | AFC control byte |
| cfg_fifo | output | 8 | FIFO control byte |
| cfg_srst_en | output | 1 | Sensitive-reset enable |
| cfg_reset_pulse | output | 1 | One-cycle pulse on any reset |

## Verification
The hardest situation to create from the ports is a frame that does not end after exactly 16 edges. That covers a frame cut short before its 16th rising edge, a frame that runs past it, and a read frame whose trailing bits would form a legal write. The bench drives these with a bit-count argument to its transfer task, and it sends reads whose remaining bits are all ones. Snapshot timing is checked by changing the status inputs right after the first falling edge and expecting the earlier value. The frequency window is swept in coarse steps across all 4096 codes, plus every value next to both bounds.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    localparam int CMD_W  = 16;
    localparam int FREQ_W = 12;
    localparam int BYTE_W = 8;

    localparam logic [3:0]        OP_FREQ  = 4'hA;
    localparam logic [BYTE_W-1:0] OP_BW    = 8'hC0;
    localparam logic [BYTE_W-1:0] OP_AFC   = 8'hC4;
    localparam logic [BYTE_W-1:0] OP_FIFO  = 8'hCA;
    localparam logic [BYTE_W-1:0] OP_MODE  = 8'hDA;
    localparam logic [CMD_W-1:0]  CMD_SRST = 16'hFF00;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [BYTE_W-1:0] bw;
        logic [BYTE_W-1:0] afc;
        logic [BYTE_W-1:0] fifo;
        logic              srst_en;
    } cfg_t;

endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scmd_shifter.sv
module scmd_shifter #(
    parameter int CMD_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              sel_n_s,
    input  logic [STAT_W-1:0] status_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              cmd_vld_o,
    output logic [CMD_W-1:0]  cmd_o
);

    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    typedef struct packed {
        logic              sck_prev;
        logic [CMD_W-1:0]  sh;
        logic [CNT_W-1:0]  cnt;
        logic              rd;
        logic [STAT_W-1:0] out;
        logic              sdo;
        logic              oe;
        logic              vld;
        logic [CMD_W-1:0]  cmd;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      rise, fall;

    always_comb begin
        rise         = sck_s & ~st_q.sck_prev;
        fall         = ~sck_s & st_q.sck_prev;
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.vld      = 1'b0;
        st_d.oe       = ~sel_n_s;
        if (sel_n_s) begin
            st_d.cnt = '0;
            st_d.rd  = 1'b0;
            st_d.sdo = 1'b0;
            st_d.sh  = '0;
            st_d.out = '0;
        end else begin
            if (rise && (st_q.cnt != CNT_FULL)) begin
                st_d.sh  = {st_q.sh[CMD_W-2:0], sdi_s};
                st_d.cnt = st_q.cnt + 1'b1;
                if ((st_q.cnt == '0) && !sdi_s) begin
                    st_d.rd  = 1'b1;
                    st_d.out = status_i;
                end
                if ((st_q.cnt == CNT_LAST) && !st_q.rd) begin
                    st_d.vld = 1'b1;
                    st_d.cmd = {st_q.sh[CMD_W-2:0], sdi_s};
                end
            end
            if (fall && st_q.rd) begin
                st_d.sdo = st_q.out[STAT_W-1];
                st_d.out = {st_q.out[STAT_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o     = st_q.sdo;
    assign sdo_oe_o  = st_q.oe;
    assign cmd_vld_o = st_q.vld;
    assign cmd_o     = st_q.cmd;

    // R6: a deselected port releases the pad and drives 0
    p_hiz_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (!sdo_oe_o && !sdo_o));

    // R2: a decoded write is a single-cycle strobe
    p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |=> !cmd_vld_o);

    // R4: a read frame never produces a write strobe
    p_no_write_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd && !sel_n_s) |=> !cmd_vld_o);

    // R4: sdo only moves on a falling serial clock edge
    p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_s && !fall) |=> $stable(sdo_o));

endmodule

// File: rtl/scmd_regfile.sv
module scmd_regfile
    import scmd_pkg::*;
#(
    parameter int          FREQ_MIN = 96,
    parameter int          FREQ_MAX = 3903,
    parameter int          DEF_FREQ = 1600,
    parameter logic [7:0]  DEF_BW   = 8'h40,
    parameter logic [7:0]  DEF_AFC  = 8'h13,
    parameter logic [7:0]  DEF_FIFO = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld_i,
    input  logic [CMD_W-1:0] cmd_i,
    output cfg_t             cfg_o,
    output logic             rst_pulse_o
);

    localparam logic [FREQ_W-1:0] F_LO = FREQ_W'(FREQ_MIN);
    localparam logic [FREQ_W-1:0] F_HI = FREQ_W'(FREQ_MAX);
    localparam cfg_t CFG_DEF = '{freq: FREQ_W'(DEF_FREQ), bw: DEF_BW,
                                 afc: DEF_AFC, fifo: DEF_FIFO, srst_en: 1'b0};

    typedef struct packed {
        cfg_t cfg;
        logic pend;
        logic pulse;
    } rf_state_t;

    rf_state_t rf_d, rf_q;
    logic      f_ok;

    always_comb begin
        f_ok     = (cmd_i[FREQ_W-1:0] >= F_LO) && (cmd_i[FREQ_W-1:0] <= F_HI);
        rf_d       = rf_q;
        rf_d.pulse = rf_q.pend;
        rf_d.pend  = 1'b0;
        if (cmd_vld_i) begin
            if (cmd_i == CMD_SRST) begin
                if (rf_q.cfg.srst_en) begin
                    rf_d.cfg   = CFG_DEF;
                    rf_d.pulse = 1'b1;
                end
            end else if (cmd_i[CMD_W-1 -: 4] == OP_FREQ) begin
                if (f_ok) begin
                    rf_d.cfg.freq = cmd_i[FREQ_W-1:0];
                end
            end else begin
                case (cmd_i[CMD_W-1 -: BYTE_W])
                    OP_BW:   rf_d.cfg.bw      = cmd_i[BYTE_W-1:0];
                    OP_AFC:  rf_d.cfg.afc     = cmd_i[BYTE_W-1:0];
                    OP_FIFO: rf_d.cfg.fifo    = cmd_i[BYTE_W-1:0];
                    OP_MODE: rf_d.cfg.srst_en = cmd_i[0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.cfg   <= CFG_DEF;
            rf_q.pend  <= 1'b1;
            rf_q.pulse <= 1'b0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign cfg_o       = rf_q.cfg;
    assign rst_pulse_o = rf_q.pulse;

    // R7: the stored frequency word never leaves the legal window
    p_freq_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o.freq >= F_LO) && (cfg_o.freq <= F_HI));

    // R7: a word below the window leaves the frequency untouched
    p_freq_low_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i[CMD_W-1 -: 4] == OP_FREQ && cmd_i[FREQ_W-1:0] < F_LO)
        |=> $stable(cfg_o.freq));

    // R10: the reset pulse lasts one cycle
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);

    // R10: registers are at defaults while the pulse is high
    p_pulse_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |-> (cfg_o == CFG_DEF));

    // R9: software reset without the enable does nothing
    p_srst_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_i == CMD_SRST && !cfg_o.srst_en) |=> (!rst_pulse_o && $stable(cfg_o)));

endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
    import scmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         MAG_W       = 5,
    parameter int         FREQ_MIN    = 96,
    parameter int         FREQ_MAX    = 3903,
    parameter int         DEF_FREQ    = 1600,
    parameter logic [7:0] DEF_BW      = 8'h40,
    parameter logic [7:0] DEF_AFC     = 8'h13,
    parameter logic [7:0] DEF_FIFO    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sel_n,
    input  logic              stat_lock,
    input  logic              stat_afc_toggle,
    input  logic              stat_afc_same,
    input  logic              stat_offs_sign,
    input  logic [MAG_W-1:0]  stat_offs_mag,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [11:0]       cfg_freq,
    output logic [7:0]        cfg_bw,
    output logic [7:0]        cfg_afc,
    output logic [7:0]        cfg_fifo,
    output logic              cfg_srst_en,
    output logic              cfg_reset_pulse
);

    localparam int STAT_W = CMD_W;
    localparam int PAD_W  = STAT_W - 4 - MAG_W;

    logic [2:0]        pins_s;
    logic [STAT_W-1:0] status_w;
    logic              cmd_vld;
    logic [CMD_W-1:0]  cmd;
    cfg_t              cfg;

    scmd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, sdi, sel_n}),
        .q     (pins_s)
    );

    assign status_w = {stat_lock, stat_afc_toggle, stat_afc_same,
                       stat_offs_sign, stat_offs_mag, {PAD_W{1'b0}}};

    scmd_shifter #(
        .CMD_W  (CMD_W),
        .STAT_W (STAT_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[2]),
        .sdi_s     (pins_s[1]),
        .sel_n_s   (pins_s[0]),
        .status_i  (status_w),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe),
        .cmd_vld_o (cmd_vld),
        .cmd_o     (cmd)
    );

    scmd_regfile #(
        .FREQ_MIN (FREQ_MIN),
        .FREQ_MAX (FREQ_MAX),
        .DEF_FREQ (DEF_FREQ),
        .DEF_BW   (DEF_BW),
        .DEF_AFC  (DEF_AFC),
        .DEF_FIFO (DEF_FIFO)
    ) u_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_vld_i   (cmd_vld),
        .cmd_i       (cmd),
        .cfg_o       (cfg),
        .rst_pulse_o (cfg_reset_pulse)
    );

    assign cfg_freq    = cfg.freq;
    assign cfg_bw      = cfg.bw;
    assign cfg_afc     = cfg.afc;
    assign cfg_fifo    = cfg.fifo;
    assign cfg_srst_en = cfg.srst_en;

endmodule

// File: tb/serial_cmd_if_tb.sv
module serial_cmd_if_tb;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, sdi = 1'b0, sel_n = 1'b1;
    logic       s_lock = 1'b0, s_tgl = 1'b0, s_same = 1'b0, s_sign = 1'b0;
    logic [4:0] s_mag = '0;
    logic       sdo, sdo_oe, srst_en, rpulse;
    logic [11:0] freq;
    logic [7:0] bw, afc, fifo;

    int checks = 0, failures = 0;
    int pulse_cnt = 0, run = 0, max_run = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_cmd_if u_dut (
        .clk (clk), .rst_n (rst_n), .sck (sck), .sdi (sdi), .sel_n (sel_n),
        .stat_lock (s_lock), .stat_afc_toggle (s_tgl), .stat_afc_same (s_same),
        .stat_offs_sign (s_sign), .stat_offs_mag (s_mag),
        .sdo (sdo), .sdo_oe (sdo_oe), .cfg_freq (freq), .cfg_bw (bw),
        .cfg_afc (afc), .cfg_fifo (fifo), .cfg_srst_en (srst_en),
        .cfg_reset_pulse (rpulse)
    );

    always @(negedge clk) begin
        if (rpulse) begin
            if (run == 0) pulse_cnt++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] w, input int n, input bit mut,
                        output logic [31:0] got, output bit oe_all);
        got = '0;
        oe_all = 1'b1;
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = w[31-i];
            repeat (H) @(negedge clk);
            if (i > 0) begin
                got = {got[30:0], sdo};
                oe_all &= sdo_oe;
            end
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
            if (mut && i == 0) begin
                s_lock = ~s_lock; s_tgl = ~s_tgl; s_mag = ~s_mag;
            end
        end
        repeat (H) @(negedge clk);
        got = {got[30:0], sdo};
        oe_all &= sdo_oe;
        sel_n = 1'b1;
        sdi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] c);
        logic [31:0] g;
        bit o;
        xfer({c, 16'h0}, 16, 1'b0, g, o);
    endtask

    task automatic chk_regs(input string req, input logic [11:0] ef, input logic [7:0] eb,
                            input logic [7:0] ea, input logic [7:0] eq, input logic ee);
        chk(freq == ef, req, 32'(freq), 32'(ef));
        chk(bw == eb, req, 32'(bw), 32'(eb));
        chk(afc == ea, req, 32'(afc), 32'(ea));
        chk(fifo == eq, req, 32'(fifo), 32'(eq));
        chk(srst_en == ee, req, 32'(srst_en), 32'(ee));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] ef;
        logic [7:0]  eb, ea, eq;
        logic [31:0] got;
        bit          oe;
        int          pc;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R10 reset state and pulse
        ef = 12'h640; eb = 8'h40; ea = 8'h13; eq = 8'h80;
        chk_regs("R10 defaults", ef, eb, ea, eq, 1'b0);
        chk(pulse_cnt == 1, "R10 por pulse", 32'(pulse_cnt), 1);
        chk(max_run == 1, "R10 pulse width", 32'(max_run), 1);
        // R6 idle pad released
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R6 idle", {30'b0, sdo_oe, sdo}, 0);

        // R8 each register
        wr(16'hC05A); eb = 8'h5A; chk_regs("R8 bw", ef, eb, ea, eq, 1'b0);
        wr(16'hC4A7); ea = 8'hA7; chk_regs("R8 afc", ef, eb, ea, eq, 1'b0);
        wr(16'hCA3C); eq = 8'h3C; chk_regs("R8 fifo", ef, eb, ea, eq, 1'b0);
        wr(16'hC1FF); chk_regs("R8 unknown opcode", ef, eb, ea, eq, 1'b0);
        wr(16'hB123); chk_regs("R8 unknown opcode B", ef, eb, ea, eq, 1'b0);

        // R7 frequency window sweep
        for (int f = 0; f < 4096 + 8; f += 53) begin
            int v;
            v = f;
            if (f >= 4096) v = 4095;
            wr({4'hA, 12'(v)});
            if (v >= 96 && v <= 3903) ef = 12'(v);
            chk(freq == ef, "R7 sweep", 32'(freq), 32'(ef));
        end
        for (int k = 0; k < 8; k++) begin
            int v;
            case (k)
                0: v = 95;   1: v = 96;   2: v = 97;   3: v = 0;
                4: v = 3904; 5: v = 3903; 6: v = 3902; default: v = 4095;
            endcase
            wr({4'hA, 12'(v)});
            if (v >= 96 && v <= 3903) ef = 12'(v);
            chk(freq == ef, "R7 boundary", 32'(freq), 32'(ef));
        end

        // R2 short frame discarded
        xfer({16'hA123, 16'h0}, 15, 1'b0, got, oe);
        chk(freq == ef, "R2 short frame", 32'(freq), 32'(ef));
        // R3 next frame decoded from first bit
        wr(16'hA200); ef = 12'h200;
        chk(freq == ef, "R3 fresh frame", 32'(freq), 32'(ef));
        // R2 extra edges ignored
        xfer({16'hC033, 16'hFFFF}, 20, 1'b0, got, oe);
        eb = 8'h33;
        chk(bw == eb, "R2 long frame", 32'(bw), 32'(eb));
        chk(oe == 1'b1, "R6 oe in frame", 32'(oe), 1);

        // R1 activity while deselected ignored
        sdi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            repeat (H) @(negedge clk); sck = 1'b1;
            repeat (H) @(negedge clk); sck = 1'b0;
        end
        sdi = 1'b0;
        repeat (6) @(negedge clk);
        chk_regs("R1 deselected", ef, eb, ea, eq, 1'b0);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R6 deselected clocks", {30'b0, sdo_oe, sdo}, 0);

        // R4 R5 status sweep
        for (int p = 0; p < 32; p++) begin
            logic [15:0] exp_w;
            s_lock = p[0]; s_tgl = p[1]; s_same = p[2]; s_sign = p[3];
            s_mag = 5'(p * 7 + 3);
            exp_w = {s_lock, s_tgl, s_same, s_sign, s_mag, 7'b0};
            xfer({16'h7FFF, 16'hFFFF}, 17, 1'b0, got, oe);
            chk(got[16:0] == {exp_w, 1'b0}, "R5 status word", {15'b0, got[16:0]}, {15'b0, exp_w, 1'b0});
            chk(oe == 1'b1, "R6 oe during read", 32'(oe), 1);
        end
        chk_regs("R4 read writes nothing", ef, eb, ea, eq, 1'b0);

        // R4 snapshot at first edge, zeros after word
        s_lock = 1'b1; s_tgl = 1'b0; s_same = 1'b1; s_sign = 1'b0; s_mag = 5'h15;
        xfer(32'h0, 20, 1'b1, got, oe);
        chk(got[19:0] == {16'hAA80, 4'h0}, "R4 snapshot and tail", {12'b0, got[19:0]}, {12'b0, 16'hAA80, 4'h0});

        // R9 gated software reset
        pc = pulse_cnt;
        wr(16'hFF00);
        chk_regs("R9 srst disabled", ef, eb, ea, eq, 1'b0);
        chk(pulse_cnt == pc, "R9 no pulse", 32'(pulse_cnt), 32'(pc));
        wr(16'hDA01);
        chk_regs("R8 mode enable", ef, eb, ea, eq, 1'b1);
        wr(16'hFF00);
        chk_regs("R9 srst defaults", 12'h640, 8'h40, 8'h13, 8'h80, 1'b0);
        chk(pulse_cnt == pc + 1, "R10 soft pulse", 32'(pulse_cnt), 32'(pc + 1));
        chk(max_run == 1, "R10 soft pulse width", 32'(max_run), 1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule